// File: doc/BRIEF.md
# Delay-Channel Conversion Trigger Scheduler

This block paces a low-rate analog converter. It holds four delay channels that all run from one shared slow timebase. The default timebase is a 2 kHz tick made by dividing the system clock. Each channel counts down a programmed number of ticks. When the count runs out, the channel expires. On expiry it fires single-cycle trigger pulses toward a chosen subset of eight conversion slots. It can also restart any of the four channels, itself included. It then reloads and fires again for a programmed number of extra rounds before it stops by itself.

Software owns one 32-bit configuration word per channel. It reaches that word through a small write port, which can replace the word, OR bits into it, or clear bits from it. Raising the word's run bit starts the channel. Clearing the run bit stops it. A per-channel busy output mirrors the run bit. This lets the system see when a sequence has ended.

With a delay of 200 ticks at 2 kHz, a channel fires every 100 ms. A channel that names other channels in its restart mask builds a chain of timed steps. A channel that names itself repeats without end.

Top module: `adc_dly_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `busy` is all zero and `slot_trig` is all zero.
- R2: The configuration word has these fields: bits 10:0 delay, bits 15:11 extra rounds, bits 19:16 restart mask (bit 16+j restarts channel j), bit 20 run, bits 31:24 slot mask (bit 24+k targets slot k). A write that takes the run bit from 0 to 1 loads the delay and the round count. `busy` for that channel is high in the cycle after the write.
- R3: The tick comes every TICK_DIV clock cycles. A running channel expires on the tick that is `delay` ticks after its start or its last reload. A delay of 0 behaves like a delay of 1.
- R4: On expiry, every slot whose mask bit is set gets a pulse exactly one cycle wide. The pulse appears in the cycle after the tick cycle. Masks of channels that expire on the same tick are ORed into one pulse.
- R5: A channel with N extra rounds expires N+1 times. On the last expiry its run bit clears by itself, and `busy` falls in the same cycle as that expiry's pulse.
- R6: On expiry, every channel selected by the restart mask (possibly the expiring one) sets its run bit and reloads its delay and its round count.
- R7: Clearing the run bit stops the channel at once, and no later triggers come from it. Writing an all-zero word leaves the channel idle with no triggers.
- R8: Write operation `wr_op`: 0 replaces the word, 1 ORs `wr_data` into it, 2 clears the bits set in `wr_data`, and 3 leaves the word untouched.
- R9: A write that leaves the run bit at 1 on a running channel does not restart it. A new delay or round count takes effect at the next reload.
- R10: When a restart from an expiry and a software write that clears the run bit hit the same channel in the same cycle, the restart wins and the channel keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe, one cycle per write |
| wr_op | input | 2 | Write operation: 0 replace, 1 set bits, 2 clear bits, 3 none |
| wr_ch | input | 2 | Channel whose configuration word is written |
| wr_data | input | 32 | Write data or bit mask |
| slot_trig | output | 8 | Registered one-cycle trigger pulse per conversion slot |
| busy | output | 4 | Run bit of each delay channel |

## Verification
Two functions can land on the same clock edge: a restart caused by an expiry, and a software write to the channel being restarted. The bench times a clear-run write onto the exact tick cycle on which a self-restarting channel expires. It then checks that the channel is still busy afterwards, and repeats the same write off the tick to check that it then stops. The bench also starts two channels between the same pair of ticks, so that they expire together and their slot masks must merge into one pulse. A behavioural model, compared on every clock, judges both cases.

// File: rtl/adc_dly_pkg.sv
package adc_dly_pkg;
  localparam int NCH     = 4;
  localparam int NSLOT   = 8;
  localparam int DLY_W   = 11;
  localparam int LOOP_W  = 5;
  localparam int RSV_W   = 3;
  localparam int CFG_W   = NSLOT + RSV_W + 1 + NCH + LOOP_W + DLY_W;
  localparam int CH_IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  // Field order fixes the bit positions software relies on.
  typedef struct packed {
    logic [NSLOT-1:0]  slots;
    logic [RSV_W-1:0]  rsv;
    logic              kick;
    logic [NCH-1:0]    chain;
    logic [LOOP_W-1:0] loops;
    logic [DLY_W-1:0]  delay;
  } dly_cfg_t;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLR   = 2'b10,
    OP_NONE  = 2'b11
  } wr_op_e;

  function automatic dly_cfg_t apply_op(dly_cfg_t cur, wr_op_e op,
                                        logic [CFG_W-1:0] d);
    dly_cfg_t r;
    case (op)
      OP_WRITE: r = dly_cfg_t'(d);
      OP_SET:   r = dly_cfg_t'(cur | d);
      OP_CLR:   r = dly_cfg_t'(cur & ~d);
      default:  r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/adc_dly_tick.sv
module adc_dly_tick #(
  parameter int DIV = 25000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_dly_chan.sv
module adc_dly_chan
  import adc_dly_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 wr_hit,
  input  wr_op_e               wr_op,
  input  logic [CFG_W-1:0]     wr_data,
  input  logic                 restart,
  output logic                 expire,
  output logic [NSLOT-1:0]     slot_mask,
  output logic [NCH-1:0]       chain_mask,
  output logic                 busy
);
  dly_cfg_t          cfg_q;
  dly_cfg_t          cfg_w;
  logic [DLY_W-1:0]  cnt_q;
  logic [LOOP_W-1:0] lp_q;
  logic              unused_rsv;

  assign unused_rsv = ^cfg_q.rsv;

  // Expiry looks only at stored state, so restart paths never loop.
  assign expire = tick & cfg_q.kick & (cnt_q <= DLY_W'(1));

  always_comb begin
    cfg_w = wr_hit ? apply_op(cfg_q, wr_op, wr_data) : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cnt_q <= '0;
      lp_q  <= '0;
    end else begin
      cfg_q <= cfg_w;
      if (restart) begin
        // R10: a restart overrides a same-cycle stop or final expiry.
        cfg_q.kick <= 1'b1;
        cnt_q      <= cfg_w.delay;
        lp_q       <= cfg_w.loops;
      end else if (wr_hit && !cfg_q.kick && cfg_w.kick) begin
        cnt_q <= cfg_w.delay;
        lp_q  <= cfg_w.loops;
      end else if (wr_hit && !cfg_w.kick) begin
        cnt_q <= cnt_q;
      end else if (expire) begin
        if (lp_q == '0) begin
          cfg_q.kick <= 1'b0;
        end else begin
          lp_q  <= lp_q - 1'b1;
          cnt_q <= cfg_w.delay;
        end
      end else if (tick && cfg_q.kick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign slot_mask  = cfg_q.slots;
  assign chain_mask = cfg_q.chain;
  assign busy       = cfg_q.kick;
endmodule

// File: rtl/adc_dly_merge.sv
module adc_dly_merge
  import adc_dly_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCH-1:0]            expire,
  input  logic [NCH-1:0][NSLOT-1:0] slot_mask,
  input  logic [NCH-1:0][NCH-1:0]   chain_mask,
  output logic [NCH-1:0]            restart,
  output logic [NSLOT-1:0]          slot_trig
);
  logic [NSLOT-1:0] trig_d;

  always_comb begin
    trig_d  = '0;
    restart = '0;
    for (int i = 0; i < NCH; i++) begin
      if (expire[i]) begin
        trig_d  = trig_d | slot_mask[i];
        restart = restart | chain_mask[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_trig <= '0;
    end else begin
      slot_trig <= trig_d;
    end
  end
endmodule

// File: rtl/adc_dly_sched.sv
module adc_dly_sched
  import adc_dly_pkg::*;
#(
  parameter int TICK_DIV = 25000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_op,
  input  logic [CH_IDX_W-1:0] wr_ch,
  input  logic [CFG_W-1:0]    wr_data,
  output logic [NSLOT-1:0]    slot_trig,
  output logic [NCH-1:0]      busy
);
  logic                      tick;
  logic [NCH-1:0]            expire;
  logic [NCH-1:0]            restart;
  logic [NCH-1:0][NSLOT-1:0] slot_mask;
  logic [NCH-1:0][NCH-1:0]   chain_mask;

  adc_dly_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    adc_dly_chan u_ch (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .wr_hit     (wr_en && (wr_ch == CH_IDX_W'(g))),
      .wr_op      (wr_op_e'(wr_op)),
      .wr_data    (wr_data),
      .restart    (restart[g]),
      .expire     (expire[g]),
      .slot_mask  (slot_mask[g]),
      .chain_mask (chain_mask[g]),
      .busy       (busy[g])
    );
  end

  adc_dly_merge u_merge (
    .clk        (clk),
    .rst        (rst),
    .expire     (expire),
    .slot_mask  (slot_mask),
    .chain_mask (chain_mask),
    .restart    (restart),
    .slot_trig  (slot_trig)
  );
endmodule

// File: rtl/adc_dly_sched_chk.sv
module adc_dly_sched_chk
  import adc_dly_pkg::*;
#(
  parameter int TICK_DIV = 25000
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [1:0]          wr_op,
  input logic [CH_IDX_W-1:0] wr_ch,
  input logic [CFG_W-1:0]    wr_data,
  input logic                tick,
  input logic [NSLOT-1:0]    slot_trig,
  input logic [NCH-1:0]      busy
);
  a_r4_trig_after_tick: assert property (@(posedge clk) disable iff (rst)
    (slot_trig != '0) |-> $past(tick));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (TICK_DIV > 1 && slot_trig != '0) |=> (slot_trig == '0));

  a_r4_trig_needs_busy: assert property (@(posedge clk) disable iff (rst)
    (slot_trig != '0) |-> ($past(busy) != '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r2_busy_rise_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(busy[g]) |-> ($past(wr_en && wr_ch == CH_IDX_W'(g)) || $past(tick)));

    a_r5_busy_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(busy[g]) |-> ($past(wr_en && wr_ch == CH_IDX_W'(g)) || $past(tick)));

    a_r7_zero_word_idle: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && wr_op == 2'b00 && wr_ch == CH_IDX_W'(g) &&
            wr_data == '0 && !tick) |-> !busy[g]);
  end
endmodule

bind adc_dly_sched adc_dly_sched_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_op     (wr_op),
  .wr_ch     (wr_ch),
  .wr_data   (wr_data),
  .tick      (tick),
  .slot_trig (slot_trig),
  .busy      (busy)
);

// File: tb/tb_adc_dly_sched.sv
module tb_adc_dly_sched;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_op = 2'b00;
  logic [1:0]  wr_ch = 2'b00;
  logic [31:0] wr_data = '0;
  logic [7:0]  slot_trig;
  logic [3:0]  busy;

  always #10 clk = ~clk;

  adc_dly_sched #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_ch(wr_ch),
    .wr_data(wr_data), .slot_trig(slot_trig), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(input logic [7:0] s, input bit k,
      input logic [3:0] c, input int lp, input int d);
    return {s, 3'b000, k, c, lp[4:0], d[10:0]};
  endfunction

  // Behavioural reference
  logic [31:0] m_cfg [4];
  int          m_cnt [4];
  int          m_lp  [4];
  logic [7:0]  m_trig;
  int          m_tc;

  always @(posedge clk) begin
    bit          tk, w, kp;
    logic [3:0]  ex, rs;
    logic [7:0]  tr;
    logic [31:0] nc;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_cfg[i] = '0; m_cnt[i] = 0; m_lp[i] = 0; end
      m_trig = '0;
      m_tc = 0;
    end else begin
      tk = (m_tc == DIV - 1);
      m_tc = tk ? 0 : m_tc + 1;
      tr = '0; rs = '0;
      for (int i = 0; i < 4; i++) begin
        ex[i] = tk && m_cfg[i][20] && (m_cnt[i] <= 1);
        if (ex[i]) begin tr |= m_cfg[i][31:24]; rs |= m_cfg[i][19:16]; end
      end
      for (int i = 0; i < 4; i++) begin
        nc = m_cfg[i];
        kp = m_cfg[i][20];
        w  = wr_en && (wr_ch == i[1:0]);
        if (w) begin
          case (wr_op)
            2'd0: nc = wr_data;
            2'd1: nc = nc | wr_data;
            2'd2: nc = nc & ~wr_data;
            default: ;
          endcase
        end
        if (rs[i]) begin
          nc[20] = 1'b1; m_cnt[i] = nc[10:0]; m_lp[i] = nc[15:11];
        end else if (w && !kp && nc[20]) begin
          m_cnt[i] = nc[10:0]; m_lp[i] = nc[15:11];
        end else if (w && !nc[20]) begin
        end else if (ex[i]) begin
          if (m_lp[i] == 0) nc[20] = 1'b0;
          else begin m_lp[i]--; m_cnt[i] = nc[10:0]; end
        end else if (tk && kp) begin
          m_cnt[i]--;
        end
        m_cfg[i] = nc;
      end
      m_trig = tr;
    end
  end

  // Output observation
  int cyc = 0;
  int pc [8];
  int lt [8];
  int gp [8];
  bit saw_or = 0;
  initial for (int k = 0; k < 8; k++) begin pc[k] = 0; lt[k] = -1; gp[k] = 0; end

  always @(negedge clk) begin
    logic [3:0] mb;
    if (!rst && !done) begin
      cyc++;
      for (int k = 0; k < 8; k++) begin
        if (slot_trig[k]) begin
          pc[k]++;
          if (lt[k] >= 0) gp[k] = cyc - lt[k];
          lt[k] = cyc;
        end
      end
      if (slot_trig == 8'h81) saw_or = 1;
      for (int i = 0; i < 4; i++) mb[i] = m_cfg[i][20];
      chk(slot_trig === m_trig, "R4 slot pulses vs model", slot_trig, m_trig);
      chk(busy === mb, "R5 busy vs model", busy, mb);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch[1:0]; wr_op = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_at(input int tcv, input int ch, input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    while (m_tc != tcv) @(negedge clk);
    wr_en = 1'b1; wr_ch = ch[1:0]; wr_op = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int b0, b1, b2, b3;
    repeat (3) @(negedge clk);
    chk(busy == 4'h0, "R1 busy in reset", busy, 0);
    chk(slot_trig == 8'h0, "R1 trig in reset", slot_trig, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 4'h0 && slot_trig == 8'h0, "R1 after release", {busy, slot_trig}, 0);

    // R2/R3/R5: delay 3, two extra rounds, slots 0 and 2
    b0 = pc[0]; b2 = pc[2];
    wr(0, 2'd0, cfgw(8'h05, 1, 4'h0, 2, 3));
    chk(busy[0] == 1'b1, "R2 kick starts channel", busy[0], 1);
    idle(3 * 3 * DIV + 10);
    chk(pc[0] - b0 == 3, "R5 slot0 fires rounds+1", pc[0] - b0, 3);
    chk(pc[2] - b2 == 3, "R5 slot2 fires rounds+1", pc[2] - b2, 3);
    chk(busy[0] == 1'b0, "R5 run bit self-clears", busy[0], 0);
    chk(gp[0] == 3 * DIV, "R3 expiry interval", gp[0], 3 * DIV);

    // R8: set and clear operations
    b1 = pc[1];
    wr(1, 2'd0, cfgw(8'h02, 0, 4'h0, 31, 2));
    idle(3 * DIV);
    chk(pc[1] == b1 && !busy[1], "R8 word without run bit idle", pc[1] - b1, 0);
    wr(1, 2'd1, 32'h0010_0000);
    chk(busy[1] == 1'b1, "R8 set op starts", busy[1], 1);
    idle(5 * DIV);
    chk(pc[1] > b1, "R8 set op kept other fields", pc[1] - b1, 2);
    wr(1, 2'd2, 32'h0010_0000);
    chk(busy[1] == 1'b0, "R7 clear op stops", busy[1], 0);
    b1 = pc[1];
    idle(5 * DIV);
    chk(pc[1] == b1, "R7 no pulses after stop", pc[1] - b1, 0);
    wr(2, 2'd3, 32'hFFFF_FFFF);
    chk(busy[2] == 1'b0, "R8 op 3 ignored", busy[2], 0);

    // R7: zero word
    b3 = pc[3];
    wr(3, 2'd0, 32'h0);
    idle(3 * DIV);
    chk(!busy[3] && pc[3] == b3, "R7 zero word idle", pc[3] - b3, 0);

    // R6: chain ch0 -> ch1
    b0 = pc[4]; b1 = pc[5];
    wr(1, 2'd0, cfgw(8'h20, 0, 4'h0, 1, 3));
    wr(0, 2'd0, cfgw(8'h10, 1, 4'h2, 0, 2));
    idle(12 * DIV);
    chk(pc[4] - b0 == 1, "R6 chain source fired once", pc[4] - b0, 1);
    chk(pc[5] - b1 == 2, "R6 chained channel ran", pc[5] - b1, 2);
    chk(busy[1:0] == 2'b00, "R6 chain finished", busy[1:0], 0);

    // R6 self-chain, R10 restart vs clear on same edge
    b2 = pc[6];
    wr(2, 2'd0, cfgw(8'h40, 1, 4'h4, 0, 1));
    idle(6 * DIV);
    chk(busy[2] && (pc[6] - b2 >= 5), "R6 self chain repeats", pc[6] - b2, 5);
    wr_at(DIV - 1, 2, 2'd2, 32'h0010_0000);
    chk(busy[2] == 1'b1, "R10 restart beats clear", busy[2], 1);
    wr_at(0, 2, 2'd2, 32'h0010_0000);
    chk(busy[2] == 1'b0, "R7 clear off tick stops", busy[2], 0);

    // R4: two channels expire together
    wr_at(0, 0, 2'd0, cfgw(8'h01, 1, 4'h0, 0, 2));
    wr(1, 2'd0, cfgw(8'h80, 1, 4'h0, 0, 2));
    idle(4 * DIV);
    chk(saw_or, "R4 merged pulse 0x81", saw_or, 1);

    // R3: delay zero acts as one tick
    b3 = pc[3];
    wr(3, 2'd0, cfgw(8'h08, 1, 4'h0, 1, 0));
    idle(4 * DIV);
    chk(gp[3] == DIV, "R3 delay zero interval", gp[3], DIV);
    chk(pc[3] - b3 == 2, "R3 delay zero count", pc[3] - b3, 2);

    // R9: rewrite while running
    wr(0, 2'd0, cfgw(8'h01, 1, 4'h0, 3, 2));
    idle(DIV);
    wr(0, 2'd0, cfgw(8'h01, 1, 4'h0, 3, 5));
    chk(busy[0] == 1'b1, "R9 rewrite keeps running", busy[0], 1);
    idle(30 * DIV);
    chk(busy[0] == 1'b0, "R9 sequence completes", busy[0], 0);

    done = 1;
    summary();
    $finish;
  end
endmodule